// File: doc/BRIEF.md
# Display Control Bus Master

This block drives a narrow, byte-wide bus that connects a graphics engine to its display-side slave chips, such as the video timing generator, colour lookup tables, pixel mappers and the RAMDAC. The host first writes a 32-bit mode word. That word chooses the slave, the starting register select, how many bytes move, the byte order, the acknowledge style and the chip-select timing. The host then writes a 32-bit data word to start a write burst, or pulses a read request to start a read burst.

The block runs one to four byte cycles. Each cycle has the same shape. The slave address, register select and data are presented first. The setup count is waited out. Chip-select is then asserted for the strobe count, and held further until an acknowledge arrives when one is enabled. Chip-select is then dropped and the hold count is waited out. Bytes are taken from the most significant lane downward unless the swap bit reverses the order. Read bytes come back into the same lanes. A busy flag covers the whole burst. A sticky error flag reports an acknowledge timeout.

Top module: `dcb_master`

## Requirements
- R1: Mode bits 1:0 set the byte count: 1, 2 and 3 are used as written and 0 means 4. When mode bit 2 (pack) is set, 4 bytes move whatever bits 1:0 hold.
- R2: For a write, byte k of the burst (k = 0 first) comes from bits [8(3-k)+7 : 8(3-k)] of the data word. When mode bit 28 (swap) is set, it comes from bits [8k+7 : 8k] instead.
- R3: For a read, the byte received in cycle k goes to the same lane that R2 gives. Lanes not reached by the burst keep their previous value. `rdata` always shows the data register.
- R4: `bus_rsel` shows mode bits 6:4. When mode bit 3 is set, the field increments modulo 8 after each byte. The incremented value stays in the mode register, so the next burst continues from it.
- R5: `bus_slave` shows mode bits 10:7. Slave code 15 starts no cycle for a data write or a read request, although a data write still loads the data register.
- R6: Each byte cycle is timed by three fields: setup (bits 27:23), strobe (bits 17:13) and hold (bits 22:18). The cycle spends setup clocks with `bus_cs` low, then max(strobe,1) clocks with `bus_cs` high, then hold clocks with `bus_cs` low.
- R7: When mode bit 11 is set, `bus_cs` stays high after the strobe count until `sync_ack` is sampled high. This wait phase lasts at least one clock.
- R8: When mode bit 12 is set, the same wait uses `async_ack` after a SYNC_STAGES-flop synchronizer. Any wait phase ends after TIMEOUT clocks without acknowledge. A timeout sets `err`, and `err` is cleared when the next burst starts.
- R9: `busy` rises on the clock edge that accepts a burst and falls after the last phase of the last byte. `bus_cs` is never high while `busy` is low. `bus_oe` is high only during write bursts.
- R10: While `busy` is high, mode writes, data writes and read requests are ignored.
- R11: After reset the block is idle: `busy`, `err` and `bus_cs` are low, and the mode and data registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Load mode register |
| mode_wdata | input | 32 | Mode word |
| data_we | input | 1 | Load data register and start a write burst |
| data_wdata | input | 32 | Data word |
| data_rd | input | 1 | Start a read burst |
| rdata | output | 32 | Data register contents |
| busy | output | 1 | Burst in progress |
| err | output | 1 | Sticky acknowledge timeout flag |
| bus_slave | output | 4 | Slave address |
| bus_rsel | output | 3 | Register select |
| bus_cs | output | 1 | Chip-select strobe, active high |
| bus_oe | output | 1 | Master drives the data lines |
| bus_dout | output | 8 | Write byte |
| bus_din | input | 8 | Read byte |
| sync_ack | input | 1 | Synchronous acknowledge |
| async_ack | input | 1 | Asynchronous acknowledge |

## Verification
The bench goes after these corner cases:

- **Zero timing fields.** A strobe field of zero must still give one chip-select clock. A design that skipped the phase would leave chip-select low for the whole byte.
- **Pack bit with a count of 1.** A design that ignored pack would send a single byte.
- **Register select wrapping from 7 to 0.** A design that saturated the select, or did not write it back, would repeat values on the next burst.
- **Swapped reads.** The bench checks that only the reached lanes change. A design that cleared the rest would corrupt the word.
- **Reserved slave code and host traffic while busy.** A design that missed the guard would start spurious cycles or overwrite the data mid-burst.
- **Acknowledge timeout.** The bench checks that chip-select stretches by exactly the timeout and that the error flag clears on the next burst.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_WAIT,
    PH_HOLD
  } phase_e;

  // mode word field positions
  localparam int MW_CNT_LSB   = 0;
  localparam int MW_PACK      = 2;
  localparam int MW_INC       = 3;
  localparam int MW_RSEL_LSB  = 4;
  localparam int MW_SLV_LSB   = 7;
  localparam int MW_SACK      = 11;
  localparam int MW_AACK      = 12;
  localparam int MW_STRB_LSB  = 13;
  localparam int MW_HOLD_LSB  = 18;
  localparam int MW_SETUP_LSB = 23;
  localparam int MW_SWAP      = 28;

  localparam int TF_W   = 5;
  localparam int RSEL_W = 3;
  localparam int SLV_W  = 4;

  localparam logic [SLV_W-1:0] SLV_NONE = '1;

endpackage

// File: rtl/dcb_ack_sync.sv
module dcb_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) sr_q <= '0;
    else     sr_q <= {sr_q[STAGES-2:0], async_i};
  end

  assign sync_o = sr_q[STAGES-1];
endmodule

// File: rtl/dcb_lane_mux.sv
module dcb_lane_mux #(
  parameter int NB = 4,
  parameter int BW = 8,
  localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic [NB*BW-1:0] word_i,
  input  logic [IW-1:0]    idx_i,
  input  logic             swap_i,
  input  logic [BW-1:0]    byte_i,
  output logic [BW-1:0]    byte_o,
  output logic [NB*BW-1:0] word_o
);
  logic [IW-1:0] lane;

  always_comb lane = swap_i ? idx_i : (IW'(NB - 1) - idx_i);

  assign byte_o = word_i[lane*BW +: BW];

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign word_o[g*BW +: BW] = (lane == IW'(g)) ? byte_i : word_i[g*BW +: BW];
  end
endmodule

// File: rtl/dcb_seq.sv
module dcb_seq
  import dcb_pkg::*;
#(
  parameter int TW      = 5,
  parameter int IW      = 2,
  parameter int TIMEOUT = 32,
  localparam int TO_W   = $clog2(TIMEOUT + 1),
  localparam int CW     = (TO_W > TW) ? TO_W : TW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [IW-1:0] last_idx_i,
  input  logic [TW-1:0] setup_i,
  input  logic [TW-1:0] strobe_i,
  input  logic [TW-1:0] hold_i,
  input  logic          ack_en_i,
  input  logic          ack_i,
  output phase_e        phase_o,
  output logic [IW-1:0] idx_o,
  output logic          byte_done_o,
  output logic          cs_end_o,
  output logic          err_o
);
  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          err_q, err_d;
  logic          enter_byte, leave_cs, finish_byte;
  logic [CW-1:0] strb_m1;

  always_comb strb_m1 = (strobe_i == '0) ? '0 : (CW'(strobe_i) - CW'(1));

  always_comb begin
    ph_d        = ph_q;
    cnt_d       = cnt_q;
    idx_d       = idx_q;
    err_d       = err_q;
    enter_byte  = 1'b0;
    leave_cs    = 1'b0;
    finish_byte = 1'b0;
    case (ph_q)
      PH_IDLE: if (start_i) begin
        err_d      = 1'b0;
        idx_d      = '0;
        enter_byte = 1'b1;
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          ph_d  = PH_STROBE;
          cnt_d = strb_m1;
        end else cnt_d = cnt_q - CW'(1);
      end
      PH_STROBE: begin
        if (cnt_q == '0) begin
          if (ack_en_i) begin
            ph_d  = PH_WAIT;
            cnt_d = CW'(TIMEOUT - 1);
          end else leave_cs = 1'b1;
        end else cnt_d = cnt_q - CW'(1);
      end
      PH_WAIT: begin
        if (ack_i) leave_cs = 1'b1;
        else if (cnt_q == '0) begin
          err_d    = 1'b1;
          leave_cs = 1'b1;
        end else cnt_d = cnt_q - CW'(1);
      end
      PH_HOLD: begin
        if (cnt_q == '0) finish_byte = 1'b1;
        else cnt_d = cnt_q - CW'(1);
      end
      default: ph_d = PH_IDLE;
    endcase
    if (leave_cs) begin
      if (hold_i != '0) begin
        ph_d  = PH_HOLD;
        cnt_d = CW'(hold_i) - CW'(1);
      end else finish_byte = 1'b1;
    end
    if (finish_byte) begin
      if (idx_q == last_idx_i) ph_d = PH_IDLE;
      else begin
        idx_d      = idx_q + IW'(1);
        enter_byte = 1'b1;
      end
    end
    if (enter_byte) begin
      if (setup_i != '0) begin
        ph_d  = PH_SETUP;
        cnt_d = CW'(setup_i) - CW'(1);
      end else begin
        ph_d  = PH_STROBE;
        cnt_d = strb_m1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      err_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      err_q <= err_d;
    end
  end

  assign phase_o     = ph_q;
  assign idx_o       = idx_q;
  assign err_o       = err_q;
  assign cs_end_o    = leave_cs;
  assign byte_done_o = finish_byte;

  // R8
  err_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> $past(ph_q == PH_WAIT));

  // R1
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_q != PH_IDLE) |-> (idx_q <= last_idx_i));

  // R6
  strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_STROBE && cnt_q != '0) |=> (ph_q == PH_STROBE));
endmodule

// File: rtl/dcb_master.sv
module dcb_master
  import dcb_pkg::*;
#(
  parameter int TIMEOUT     = 32,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 32,
  parameter int BYTE_W      = 8,
  localparam int NB         = DATA_W / BYTE_W,
  localparam int IW         = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_we,
  input  logic [31:0]       mode_wdata,
  input  logic              data_we,
  input  logic [DATA_W-1:0] data_wdata,
  input  logic              data_rd,
  output logic [DATA_W-1:0] rdata,
  output logic              busy,
  output logic              err,
  output logic [SLV_W-1:0]  bus_slave,
  output logic [RSEL_W-1:0] bus_rsel,
  output logic              bus_cs,
  output logic              bus_oe,
  output logic [BYTE_W-1:0] bus_dout,
  input  logic [BYTE_W-1:0] bus_din,
  input  logic              sync_ack,
  input  logic              async_ack
);
  logic [31:0]       mode_q;
  logic [DATA_W-1:0] data_q, data_merged;
  logic              rd_q;
  phase_e            phase;
  logic [IW-1:0]     idx, last_idx;
  logic              byte_done, cs_end, start_go, host_ok;
  logic              aack_s, ack_in;
  logic [1:0]        cnt_f;

  assign cnt_f     = mode_q[MW_CNT_LSB +: 2];
  assign bus_slave = mode_q[MW_SLV_LSB +: SLV_W];
  assign bus_rsel  = mode_q[MW_RSEL_LSB +: RSEL_W];

  always_comb begin
    if (mode_q[MW_PACK] || cnt_f == 2'd0) last_idx = IW'(NB - 1);
    else                                   last_idx = IW'(cnt_f) - IW'(1);
  end

  assign busy     = (phase != PH_IDLE);
  assign host_ok  = !busy;
  assign start_go = host_ok && (data_we || data_rd) && (bus_slave != SLV_NONE);
  assign ack_in   = (mode_q[MW_SACK] && sync_ack) || (mode_q[MW_AACK] && aack_s);

  dcb_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (async_ack),
    .sync_o  (aack_s)
  );

  dcb_seq #(.TW(TF_W), .IW(IW), .TIMEOUT(TIMEOUT)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_go),
    .last_idx_i  (last_idx),
    .setup_i     (mode_q[MW_SETUP_LSB +: TF_W]),
    .strobe_i    (mode_q[MW_STRB_LSB +: TF_W]),
    .hold_i      (mode_q[MW_HOLD_LSB +: TF_W]),
    .ack_en_i    (mode_q[MW_SACK] || mode_q[MW_AACK]),
    .ack_i       (ack_in),
    .phase_o     (phase),
    .idx_o       (idx),
    .byte_done_o (byte_done),
    .cs_end_o    (cs_end),
    .err_o       (err)
  );

  dcb_lane_mux #(.NB(NB), .BW(BYTE_W)) u_lane (
    .word_i (data_q),
    .idx_i  (idx),
    .swap_i (mode_q[MW_SWAP]),
    .byte_i (bus_din),
    .byte_o (bus_dout),
    .word_o (data_merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      data_q <= '0;
      rd_q   <= 1'b0;
    end else begin
      if (host_ok && mode_we) mode_q <= mode_wdata;
      if (host_ok && data_we) data_q <= data_wdata;
      if (start_go) rd_q <= !data_we;
      if (byte_done && mode_q[MW_INC])
        mode_q[MW_RSEL_LSB +: RSEL_W] <= bus_rsel + RSEL_W'(1);
      if (cs_end && rd_q) data_q <= data_merged;
    end
  end

  assign rdata  = data_q;
  assign bus_cs = (phase == PH_STROBE) || (phase == PH_WAIT);
  assign bus_oe = busy && !rd_q;

  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    start_go |=> busy);

  // R9
  cs_busy_chk: assert property (@(posedge clk) disable iff (rst)
    bus_cs |-> busy);

  // R5
  reserved_chk: assert property (@(posedge clk) disable iff (rst)
    ((data_we || data_rd) && !busy && bus_slave == SLV_NONE) |=> !busy);

  // R10
  ignore_slave_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && mode_we) |=> $stable(bus_slave));

  // R10
  ignore_data_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !rd_q && data_we) |=> $stable(rdata));
endmodule

// File: tb/sim_dcb_master.sv
module sim_dcb_master;
  localparam int TO = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_we = 1'b0, data_we = 1'b0, data_rd = 1'b0;
  logic [31:0] mode_wdata = '0, data_wdata = '0;
  logic [31:0] rdata;
  logic        busy, err, bus_cs, bus_oe;
  logic [3:0]  bus_slave;
  logic [2:0]  bus_rsel;
  logic [7:0]  bus_dout, bus_din;
  logic        sync_ack = 1'b0, async_ack = 1'b0;

  always #5 clk = ~clk;

  dcb_master #(.TIMEOUT(TO)) u0 (
    .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .data_we(data_we), .data_wdata(data_wdata), .data_rd(data_rd),
    .rdata(rdata), .busy(busy), .err(err), .bus_slave(bus_slave),
    .bus_rsel(bus_rsel), .bus_cs(bus_cs), .bus_oe(bus_oe),
    .bus_dout(bus_dout), .bus_din(bus_din), .sync_ack(sync_ack),
    .async_ack(async_ack)
  );

  // behavioural slave: read byte depends on the register select
  assign bus_din = 8'hA0 + {5'd0, bus_rsel};

  int n_chk = 0, n_fail = 0;
  int q_cs[$], q_rs[$], q_do[$], q_oe[$];
  logic [31:0] m_mode = '0, m_data = '0;
  logic m_busy = 1'b0, m_err = 1'b0;
  bit   ack_ok = 1'b1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int w, int pack, int inc, int rsel, int slv,
                                     int sack, int aack, int strb, int hold,
                                     int setup, int swap);
    logic [31:0] m = '0;
    m[1:0] = 2'(w);      m[2] = 1'(pack);    m[3] = 1'(inc);
    m[6:4] = 3'(rsel);   m[10:7] = 4'(slv);  m[11] = 1'(sack);
    m[12] = 1'(aack);    m[17:13] = 5'(strb); m[22:18] = 5'(hold);
    m[27:23] = 5'(setup); m[28] = 1'(swap);
    return m;
  endfunction

  // reference model: one queue entry per expected busy clock
  task automatic issue(input bit rd);
    int nb, w1, wt, lane, r, base;
    bit ackon, inc, swp;
    nb    = (m_mode[2] || m_mode[1:0] == 2'd0) ? 4 : int'(m_mode[1:0]);
    w1    = (m_mode[17:13] == 5'd0) ? 1 : int'(m_mode[17:13]);
    ackon = m_mode[11] || m_mode[12];
    wt    = ackon ? (ack_ok ? 1 : TO) : 0;
    inc   = m_mode[3];
    swp   = m_mode[28];
    base  = int'(m_mode[6:4]);
    for (int k = 0; k < nb; k++) begin
      r    = (base + (inc ? k : 0)) % 8;
      lane = swp ? k : 3 - k;
      for (int c = 0; c < int'(m_mode[27:23]); c++) begin
        q_cs.push_back(0); q_rs.push_back(r); q_do.push_back(-1); q_oe.push_back(!rd);
      end
      for (int c = 0; c < w1 + wt; c++) begin
        q_cs.push_back(1); q_rs.push_back(r); q_oe.push_back(!rd);
        q_do.push_back(rd ? -1 : int'(m_data[lane*8 +: 8]));
      end
      for (int c = 0; c < int'(m_mode[22:18]); c++) begin
        q_cs.push_back(0); q_rs.push_back(r); q_do.push_back(-1); q_oe.push_back(!rd);
      end
      if (rd) m_data[lane*8 +: 8] = 8'hA0 + 8'(r);
    end
    if (inc) m_mode[6:4] = 3'(base + nb);
    m_err = ackon && !ack_ok;
  endtask

  task automatic host_mode(input logic [31:0] v);
    @(posedge clk); #6;
    mode_we = 1'b1; mode_wdata = v;
    if (!m_busy) m_mode = v;
    @(posedge clk); #6;
    mode_we = 1'b0;
  endtask

  task automatic host_write(input logic [31:0] v);
    @(posedge clk); #6;
    data_we = 1'b1; data_wdata = v;
    if (!m_busy) begin
      m_data = v;
      if (m_mode[10:7] != 4'hF) issue(1'b0);
    end
    @(posedge clk); #6;
    data_we = 1'b0;
  endtask

  task automatic host_read();
    @(posedge clk); #6;
    data_rd = 1'b1;
    if (!m_busy && m_mode[10:7] != 4'hF) issue(1'b1);
    @(posedge clk); #6;
    data_rd = 1'b0;
  endtask

  task automatic wait_idle();
    while (q_cs.size() != 0 || m_busy) @(posedge clk);
    #1;
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin : cmp
    int cs, rs, dv, oe;
    if (!rst) begin
      if (q_cs.size() > 0) begin
        cs = q_cs.pop_front(); rs = q_rs.pop_front();
        dv = q_do.pop_front(); oe = q_oe.pop_front();
        chk(busy === 1'b1, "R1 R9", "busy during burst", 32'(busy), 1);
        chk(bus_cs === 1'(cs), "R6 R7 R8", "bus_cs", 32'(bus_cs), 32'(cs));
        chk(bus_rsel == 3'(rs), "R4", "bus_rsel", 32'(bus_rsel), 32'(rs));
        chk(bus_oe === 1'(oe), "R9", "bus_oe", 32'(bus_oe), 32'(oe));
        if (dv >= 0) chk(bus_dout == 8'(dv), "R2", "bus_dout", 32'(bus_dout), 32'(dv));
        m_busy = 1'b1;
      end else begin
        chk(busy === 1'b0 && bus_cs === 1'b0, "R9", "idle busy/cs",
            {30'd0, busy, bus_cs}, 0);
        m_busy = 1'b0;
      end
      chk(bus_slave == m_mode[10:7], "R5", "bus_slave", 32'(bus_slave), 32'(m_mode[10:7]));
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog: burst never finished, actual busy %0d expected 0", busy);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #6 rst = 1'b0;
    // R11 reset state
    chk(busy == 1'b0, "R11", "busy", 32'(busy), 0);
    chk(err == 1'b0, "R11", "err", 32'(err), 0);
    chk(bus_cs == 1'b0, "R11", "bus_cs", 32'(bus_cs), 0);
    chk(rdata == 32'd0, "R11", "rdata", rdata, 0);

    // R1 R2 R4 R6: 3 bytes, auto-increment, setup 2 strobe 1 hold 1
    host_mode(mk(3, 0, 1, 0, 2, 0, 0, 1, 1, 2, 0));
    host_write(32'h12345600);
    wait_idle();
    // R4: select continues from 3 on the next burst
    host_write(32'hA1B2C3D4);
    wait_idle();

    // R1 R6: count 0 means 4 bytes; strobe 0 behaves as 1, no setup/hold
    host_mode(mk(0, 0, 0, 5, 3, 0, 0, 0, 0, 0, 0));
    host_write(32'hDEADBEEF);
    wait_idle();

    // R1 R2 R4: pack with count 1, swapped order, select wraps 6,7,0,1
    host_mode(mk(1, 1, 1, 6, 4, 0, 0, 2, 0, 1, 1));
    host_write(32'h01020304);
    wait_idle();
    chk(bus_rsel == 3'd2, "R4", "rsel after wrap", 32'(bus_rsel), 2);

    // R3: 1-byte read lands in the top lane
    host_mode(mk(1, 0, 0, 2, 1, 0, 0, 1, 0, 0, 0));
    host_read();
    wait_idle();
    chk(rdata == m_data, "R3", "1-byte read", rdata, m_data);
    chk(rdata == 32'hA2020304, "R3", "1-byte read literal", rdata, 32'hA2020304);

    // R3: 2-byte swapped read fills the two low lanes only
    host_mode(mk(2, 0, 1, 4, 1, 0, 0, 1, 1, 1, 1));
    host_read();
    wait_idle();
    chk(rdata == 32'hA202A5A4, "R3", "swapped read", rdata, 32'hA202A5A4);

    // R5: reserved slave code
    host_mode(mk(3, 0, 0, 0, 15, 0, 0, 1, 0, 0, 0));
    host_write(32'hCAFEF00D);
    repeat (3) @(posedge clk);
    #1 chk(rdata == 32'hCAFEF00D, "R5", "data loaded for code 15", rdata, 32'hCAFEF00D);
    host_read();
    repeat (3) @(posedge clk);
    #1 chk(busy == 1'b0 && rdata == 32'hCAFEF00D, "R5", "read with code 15",
           rdata, 32'hCAFEF00D);

    // R7: synchronous acknowledge
    sync_ack = 1'b1; ack_ok = 1'b1;
    host_mode(mk(1, 0, 0, 1, 2, 1, 0, 2, 1, 0, 0));
    host_write(32'h5A000000);
    wait_idle();
    chk(err == 1'b0, "R7", "err after sync ack", 32'(err), 0);
    sync_ack = 1'b0;

    // R8: asynchronous acknowledge present
    async_ack = 1'b1;
    repeat (4) @(posedge clk);
    host_mode(mk(2, 0, 0, 0, 9, 0, 1, 1, 0, 1, 0));
    host_write(32'h77660000);
    wait_idle();
    chk(err == 1'b0, "R8", "err with async ack", 32'(err), 0);

    // R8: timeout
    async_ack = 1'b0; ack_ok = 1'b0;
    repeat (4) @(posedge clk);
    host_mode(mk(1, 0, 0, 0, 9, 0, 1, 1, 1, 1, 0));
    host_write(32'h3C000000);
    wait_idle();
    chk(err == 1'b1, "R8", "err after timeout", 32'(err), 32'(m_err));
    async_ack = 1'b1; ack_ok = 1'b1;
    repeat (4) @(posedge clk);
    host_write(32'h3D000000);
    wait_idle();
    chk(err == 1'b0, "R8", "err cleared by next burst", 32'(err), 0);

    // R10: host traffic while busy is ignored
    host_mode(mk(2, 0, 0, 0, 6, 0, 0, 2, 2, 3, 0));
    host_write(32'h11223344);
    host_mode(mk(1, 0, 0, 0, 8, 0, 0, 1, 0, 0, 0));
    host_write(32'h99999999);
    host_read();
    wait_idle();
    chk(rdata == 32'h11223344, "R10", "data kept", rdata, 32'h11223344);
    chk(bus_slave == 4'd6, "R10", "slave kept", 32'(bus_slave), 6);

    repeat (3) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule